// File: doc/BRIEF.md
# SPI Command and Status Slave

This block is the host-facing side of a serial-to-audio bridge. A host acting as SPI master talks to it in fixed frames. In each frame, chip select goes low and 24 bits move in each direction. On MOSI the host sends a command byte and then a 16-bit payload. On MISO the slave returns a status byte and then the most recently received audio word. Clock idle level is low and data is sampled on the falling edge (CPOL=0, CPHA=1). Bits travel most significant first.

The serial pins are synchronised into a faster system clock, and edges are found there. A command whose top bit is set is handed to the downstream command queue. If the command asks for transmission, its payload is also handed to the data queue. The queues and the audio engine sit outside this block. They appear only as push/ready pairs and as status inputs. An audio word arriving from the engine is held with its channel and a valid flag. That flag is cleared once a complete frame has carried the word out to the host.

Top module: `spi_frame_slave`

## Requirements
- R1: A frame is 24 bits taken MSB first, sampled on falling SCLK edges while CS is low. Bits 23..16 form the command and bits 15..0 form the payload. The command and payload appear on `cmd_byte` and `data_word` when pushed.
- R2: The first 8 MISO bits of a frame are the status byte, MSB first: `cur_ws`, `dir_tx`, held word channel, held word valid, `dq_level[1:0]`, `cq_level[1:0]`. The last 16 bits are the held received word.
- R3: The command is pushed (`cmd_push` high for one cycle) only when command bit 7 is 1. When it is 0, nothing is pushed.
- R4: The payload is pushed on `data_push` only together with a pushed command whose bit 0 (transmit request) is 1. Otherwise the payload is ignored.
- R5: A pulse on `rx_strobe` stores `rx_word` and `rx_ch` and sets the valid flag. The flag clears after a complete frame that began with it set. A new strobe takes precedence over the clear.
- R6: If CS rises before 24 bits have arrived, the frame is discarded: nothing is pushed, the valid flag is kept, and the next frame starts from bit 0.
- R7: The status byte and returned word are captured when CS falls. Input changes during the frame do not alter them.
- R8: A command with bit 7 set is dropped when `cmd_ready` is low, or when it requests transmission and `data_ready` is low. A dropped command sets `overflow`, which stays set until reset.
- R9: After reset `miso`, `overflow`, `cmd_push` and `data_push` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Host-to-slave serial data |
| miso | output | 1 | Slave-to-host serial data, low while deselected |
| cur_ws | input | 1 | Current audio channel from the engine |
| dir_tx | input | 1 | Engine is transmitting (1) or receiving (0) |
| dq_level | input | 2 | Data queue occupancy code |
| cq_level | input | 2 | Command queue occupancy code |
| rx_strobe | input | 1 | One-cycle pulse: a received audio word is offered |
| rx_word | input | DAT_W | Received audio word |
| rx_ch | input | 1 | Channel of the received word |
| cmd_ready | input | 1 | Command queue can accept |
| data_ready | input | 1 | Data queue can accept |
| cmd_push | output | 1 | Command push strobe |
| cmd_byte | output | 8 | Command pushed |
| data_push | output | 1 | Payload push strobe |
| data_word | output | DAT_W | Payload pushed |
| overflow | output | 1 | Sticky: a valid command was dropped |

## Verification
A bit counter that is off by one shows up in the first frame: it shifts the decoded command and payload and misplaces the check and transmit bits, so the wrong pushes follow within a few system cycles after the last falling SCLK edge. A valid flag that is stuck or clears early is visible on the next frame's status byte. A counter not cleared on abort corrupts the frame that follows the aborted one. A snapshot taken at the wrong time shows as status bits that follow inputs changed mid-frame.

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  input  logic             cur_ws,
  input  logic             dir_tx,
  input  logic [1:0]       dq_level,
  input  logic [1:0]       cq_level,
  input  logic             rx_strobe,
  input  logic [DAT_W-1:0] rx_word,
  input  logic             rx_ch,
  input  logic             cmd_ready,
  input  logic             data_ready,
  output logic             cmd_push,
  output logic [7:0]       cmd_byte,
  output logic             data_push,
  output logic [DAT_W-1:0] data_word,
  output logic             overflow
);
  localparam int FR = 8 + DAT_W;
  localparam int CW = $clog2(FR + 1);

  logic [2:0]       sclk_p;
  logic [1:0]       cs_p;
  logic             cs_q;
  logic [1:0]       mosi_p;
  logic [CW-1:0]    cnt;
  logic [FR-1:0]    sh_in, sh_out;
  logic             fin, vsnap;
  logic [DAT_W-1:0] word_q;
  logic             ch_q, valid_q;

  wire sclk_fall = sclk_p[2] & ~sclk_p[1];
  wire cs_act    = ~cs_p[1];
  wire cs_fall   = cs_q & ~cs_p[1];
  wire [7:0] status = {cur_ws, dir_tx, ch_q, valid_q, dq_level, cq_level};

  wire chk  = sh_in[FR-1];
  wire txr  = sh_in[FR-8];
  wire room = cmd_ready & (~txr | data_ready);

  assign miso = cs_act & sh_out[FR-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= 2'b11;
      cs_q   <= 1'b1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[0], cs_n};
      cs_q   <= cs_p[1];
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh_in  <= '0;
      sh_out <= '0;
      fin    <= 1'b0;
      vsnap  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        sh_out <= {status, word_q};
        vsnap  <= valid_q;
      end else if (!cs_act) begin
        cnt <= '0;
      end else if (sclk_fall && cnt != CW'(FR)) begin
        sh_in  <= {sh_in[FR-2:0], mosi_p[1]};
        sh_out <= {sh_out[FR-2:0], 1'b0};
        cnt    <= cnt + 1'b1;
        fin    <= (cnt == CW'(FR - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_push  <= 1'b0;
      data_push <= 1'b0;
      cmd_byte  <= '0;
      data_word <= '0;
      overflow  <= 1'b0;
    end else begin
      cmd_push  <= fin & chk & room;
      data_push <= fin & chk & room & txr;
      overflow  <= overflow | (fin & chk & ~room);
      if (fin) begin
        cmd_byte  <= sh_in[FR-1 -: 8];
        data_word <= sh_in[DAT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ch_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (rx_strobe) begin
      word_q  <= rx_word;
      ch_q    <= rx_ch;
      valid_q <= 1'b1;
    end else if (fin && vsnap) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_push,
  input logic [7:0] cmd_byte,
  input logic       data_push,
  input logic       cmd_ready,
  input logic       data_ready,
  input logic       overflow
);
  AST_CMD_CHECKBIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> cmd_byte[7]); // R3
  AST_DATA_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    data_push |-> (cmd_push && cmd_byte[0])); // R4
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |=> !cmd_push); // R1
  AST_PUSH_HAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> $past(cmd_ready)); // R8
  AST_DATA_HAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    data_push |-> $past(data_ready)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
endmodule

bind spi_frame_slave spi_frame_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_byte(cmd_byte),
  .data_push(data_push), .cmd_ready(cmd_ready), .data_ready(data_ready),
  .overflow(overflow)
);

// File: tb/sim_spi_frame_slave.sv
`timescale 1ns/1ps
module sim_spi_frame_slave;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic cur_ws = 1, dir_tx = 0;
  logic [1:0] dq_level = 2'b10, cq_level = 2'b01;
  logic rx_strobe = 0, rx_ch = 0;
  logic [15:0] rx_word = '0;
  logic cmd_ready = 1, data_ready = 1;
  logic miso, cmd_push, data_push, overflow;
  logic [7:0] cmd_byte;
  logic [15:0] data_word;

  int errors = 0, checks = 0;
  int ncmd = 0, ndat = 0;
  logic [7:0] last_cmd;
  logic [15:0] last_dat;
  localparam int HALF = 40;

  always #2.5 clk = ~clk;

  spi_frame_slave u0 (.*);

  always @(negedge clk) begin
    if (cmd_push) begin ncmd++; last_cmd = cmd_byte; end
    if (data_push) begin ndat++; last_dat = data_word; end
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
    rx = '0;
    cs_n = 0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; mosi = tx[23-i];
      #(HALF);
      rx[23-i] = miso;
      sclk = 0;
      #(HALF);
    end
    cs_n = 1;
    #(4*HALF);
  endtask

  task automatic strobe(input logic [15:0] w, input logic ch);
    rx_word = w; rx_ch = ch; rx_strobe = 1;
    #5; rx_strobe = 0;
    #10;
  endtask

  task automatic t_reset;
    chk(miso == 0, "R9 miso", {23'd0, miso}, 0);
    chk(overflow == 0, "R9 overflow", {23'd0, overflow}, 0);
    chk(ncmd == 0 && ndat == 0, "R9 pushes", ncmd + ndat, 0);
  endtask

  task automatic t_tx_cmd;
    logic [23:0] rx;
    int c0 = ncmd, d0 = ndat;
    xfer({8'h81, 16'hA55A}, 24, rx);
    chk(rx == {8'b1_0_0_0_10_01, 16'h0}, "R2 status idle", rx, {8'h89, 16'h0});
    chk(ncmd == c0 + 1 && last_cmd == 8'h81, "R1 cmd", {ncmd[7:0], last_cmd}, {8'(c0+1), 8'h81});
    chk(ndat == d0 + 1 && last_dat == 16'hA55A, "R1 data", {ndat[7:0], last_dat}, {8'(d0+1), 16'hA55A});
  endtask

  task automatic t_no_check;
    logic [23:0] rx;
    int c0 = ncmd, d0 = ndat;
    xfer({8'h7F, 16'h1234}, 24, rx);
    chk(ncmd == c0 && ndat == d0, "R3 no push", ncmd + ndat, c0 + d0);
  endtask

  task automatic t_rx_cmd;
    logic [23:0] rx;
    int c0 = ncmd, d0 = ndat;
    xfer({8'hC4, 16'hFFFF}, 24, rx);
    chk(ncmd == c0 + 1 && last_cmd == 8'hC4, "R4 cmd pushed", last_cmd, 8'hC4);
    chk(ndat == d0, "R4 payload ignored", ndat, d0);
  endtask

  task automatic t_valid;
    logic [23:0] rx;
    strobe(16'hBEEF, 1);
    xfer(24'h0, 24, rx);
    chk(rx == {8'b1_0_1_1_10_01, 16'hBEEF}, "R5 word read", rx, {8'hB9, 16'hBEEF});
    xfer(24'h0, 24, rx);
    chk(rx[20] == 0, "R5 valid cleared", rx[23:16], 8'hA9);
  endtask

  task automatic t_abort;
    logic [23:0] rx;
    int c0 = ncmd;
    strobe(16'h0F0F, 0);
    xfer({8'h80, 16'h0}, 10, rx);
    chk(ncmd == c0, "R6 abort no push", ncmd, c0);
    xfer({8'h82, 16'h0}, 24, rx);
    chk(rx == {8'b1_0_0_1_10_01, 16'h0F0F}, "R6 valid kept", rx, {8'h99, 16'h0F0F});
    chk(ncmd == c0 + 1 && last_cmd == 8'h82, "R6 restart", last_cmd, 8'h82);
  endtask

  task automatic t_snapshot;
    logic [23:0] rx;
    cs_n = 0;
    #(HALF);
    cur_ws = 0; dir_tx = 1; dq_level = 2'b11; cq_level = 2'b11;
    strobe(16'h5555, 1);
    #(HALF);
    for (int i = 0; i < 24; i++) begin
      sclk = 1; mosi = 0;
      #(HALF);
      rx[23-i] = miso;
      sclk = 0;
      #(HALF);
    end
    cs_n = 1;
    #(4*HALF);
    chk(rx == {8'b1_0_0_0_10_01, 16'h0F0F}, "R7 snapshot", rx, {8'h89, 16'h0F0F});
    xfer(24'h0, 24, rx);
    chk(rx == {8'b0_1_1_1_11_11, 16'h5555}, "R7 new frame", rx, {8'h7F, 16'h5555});
    cur_ws = 1; dir_tx = 0; dq_level = 2'b10; cq_level = 2'b01;
  endtask

  task automatic t_overflow;
    logic [23:0] rx;
    int c0 = ncmd;
    cmd_ready = 0;
    xfer({8'h81, 16'h1111}, 24, rx);
    chk(ncmd == c0, "R8 dropped", ncmd, c0);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    cmd_ready = 1; data_ready = 0;
    xfer({8'h81, 16'h2222}, 24, rx);
    chk(ncmd == c0, "R8 data full drop", ncmd, c0);
    data_ready = 1;
    xfer({8'h80, 16'h0}, 24, rx);
    chk(ncmd == c0 + 1, "R8 push resumes", ncmd, c0 + 1);
    chk(overflow == 1, "R8 sticky", overflow, 1);
  endtask

  initial begin
    #500_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50; rst_n = 1; #50;
    t_reset();
    t_tx_cmd();
    t_no_check();
    t_rx_cmd();
    t_valid();
    t_abort();
    t_snapshot();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule